// File: doc/BRIEF.md
# AM Modulator with Offset-Binary DAC Output

This block is the back end of a digital AM transmitter. On every clock it takes a signed 16-bit carrier sample and a signed 16-bit modulating sample. The modulating sample is either an internally generated tone or an external audio sample, chosen by a select input. The modulating sample is raised by a fixed DC level of 0x4000, which sets the unmodulated carrier amplitude. The block multiplies the carrier by this biased envelope in a signed fixed-point format. It then turns the signed result into a 10-bit unsigned code for a high-speed video DAC, which is used as an RF output.

The DC-biased envelope is clipped to the signed 16-bit range. Overmodulation therefore flattens the envelope at full scale instead of wrapping to a negative value and inverting the carrier phase. The carrier and the envelope are registered on entry, and the DAC code is registered on exit. The DAC blanking and sync controls are held inactive-high, and the DAC clock output is the system clock.

Top module: `am_mod_dac`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, dac_code_o is 512. dac_blank_o and dac_sync_o are 1 at all times, including during reset.
- R2: With src_sel_i = 0 the modulating sample is tone_i. audio_i has no effect on dac_code_o.
- R3: With src_sel_i = 1 the modulating sample is audio_i. tone_i has no effect on dac_code_o.
- R4: The envelope is the signed modulating sample plus 16384 (0x4000). If that sum exceeds 32767 it is clamped to 32767 (0x7FFF) instead of wrapping.
- R5: The carrier and the envelope are multiplied as signed 16-bit values into a 32-bit product. The 16-bit modulated result is product bit 31 followed by product bits 29 down to 15.
- R6: dac_code_o is bits 15:6 of the modulated result plus 512, modulo 1024. This is offset binary: two's complement zero maps to 512.
- R7: A carrier sample of 0 gives dac_code_o = 512 for any modulating sample and any select value.
- R8: carrier_i, tone_i, audio_i and src_sel_i are sampled on a rising clock edge. The resulting code appears on dac_code_o after the next rising edge. Between those two edges the previous code is held.
- R9: dac_clk_o follows clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also forwarded to the DAC |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_i | input | 16 | Signed carrier sample |
| tone_i | input | 16 | Signed internal tone sample |
| audio_i | input | 16 | Signed external audio sample |
| src_sel_i | input | 1 | Modulating source: 0 tone, 1 audio |
| dac_code_o | output | 10 | Offset-binary DAC code |
| dac_blank_o | output | 1 | DAC blanking control, held at 1 |
| dac_sync_o | output | 1 | DAC sync control, held at 1 |
| dac_clk_o | output | 1 | DAC sample clock |

## Verification
A grid of 64 carrier values by 64 modulating values is applied for both select settings. The grid spans the full signed range, so it covers sign changes of the product and wrap of the offset-binary code. On every grid vector the unselected source carries a different value, so a swapped or stuck select shows up as a code mismatch. Directed vectors pin down the saturation knee (0x3FFF against 0x4000 and above), the full-scale corner products whose signs separate a correct bit slice from an off-by-one slice, and a zero carrier under extreme envelopes. A step from one vector to another checks that the old code is held for exactly one cycle before the new one appears.

// File: rtl/am_mod_pkg.sv
package am_mod_pkg;
    localparam int SAMPLE_W = 16;
    localparam int CODE_W   = 10;
    localparam logic [SAMPLE_W-1:0] ENV_OFFSET = 16'h4000;
endpackage

// File: rtl/am_mod_src_sel.sv
module am_mod_src_sel #(
    parameter int              DW     = am_mod_pkg::SAMPLE_W,
    parameter logic [DW-1:0]   OFFSET = am_mod_pkg::ENV_OFFSET
) (
    input  logic [DW-1:0] tone_i,
    input  logic [DW-1:0] audio_i,
    input  logic          sel_i,
    output logic [DW-1:0] env_o
);
    localparam logic signed [DW:0] POS_MAX = (DW+1)'((1 << (DW-1)) - 1);
    localparam logic signed [DW:0] NEG_MIN = -(DW+1)'(1 << (DW-1));

    logic [DW-1:0]      pick;
    logic signed [DW:0] sum;

    always_comb begin
        pick = sel_i ? audio_i : tone_i;
        sum  = $signed({pick[DW-1], pick}) + $signed({1'b0, OFFSET});
        if (sum > POS_MAX) begin
            env_o = POS_MAX[DW-1:0];
        end else if (sum < NEG_MIN) begin
            env_o = NEG_MIN[DW-1:0];
        end else begin
            env_o = sum[DW-1:0];
        end
    end
endmodule

// File: rtl/am_mod_mult.sv
module am_mod_mult #(
    parameter int DW = am_mod_pkg::SAMPLE_W
) (
    input  logic [DW-1:0] carrier_i,
    input  logic [DW-1:0] env_i,
    output logic [DW-1:0] result_o
);
    logic signed [2*DW-1:0] prod;
    logic [DW-1:0]          unused_prod_bits;

    always_comb begin
        prod             = $signed(carrier_i) * $signed(env_i);
        result_o         = {prod[2*DW-1], prod[2*DW-3:DW-1]};
        unused_prod_bits = {prod[2*DW-2], prod[DW-2:0]};
    end
endmodule

// File: rtl/am_mod_dac_fmt.sv
module am_mod_dac_fmt #(
    parameter int DW = am_mod_pkg::SAMPLE_W,
    parameter int CW = am_mod_pkg::CODE_W
) (
    input  logic [DW-1:0] result_i,
    output logic [CW-1:0] code_o
);
    localparam logic [CW-1:0] MID = CW'(1 << (CW-1));

    logic [DW-CW-1:0] unused_frac;

    always_comb begin
        code_o      = result_i[DW-1:DW-CW] + MID;
        unused_frac = result_i[DW-CW-1:0];
    end
endmodule

// File: rtl/am_mod_dac.sv
module am_mod_dac #(
    parameter int                DW     = am_mod_pkg::SAMPLE_W,
    parameter int                CW     = am_mod_pkg::CODE_W,
    parameter logic [DW-1:0]     OFFSET = am_mod_pkg::ENV_OFFSET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] carrier_i,
    input  logic [DW-1:0] tone_i,
    input  logic [DW-1:0] audio_i,
    input  logic          src_sel_i,
    output logic [CW-1:0] dac_code_o,
    output logic          dac_blank_o,
    output logic          dac_sync_o,
    output logic          dac_clk_o
);
    localparam logic [CW-1:0] MID       = CW'(1 << (CW-1));
    localparam int            SAT_KNEE  = (1 << (DW-1)) - 1 - int'(OFFSET);
    localparam int            ENV_FLOOR = int'(OFFSET) - (1 << (DW-1));
    localparam logic [DW-1:0] ENV_MAX   = DW'((1 << (DW-1)) - 1);

    typedef struct packed {
        logic [DW-1:0] carrier;
        logic [DW-1:0] env;
        logic [CW-1:0] code;
    } pipe_t;

    pipe_t         pipe_d, pipe_q;
    logic [DW-1:0] env_new;
    logic [DW-1:0] mod_result;
    logic [CW-1:0] code_new;

    am_mod_src_sel #(.DW(DW), .OFFSET(OFFSET)) u_src (
        .tone_i  (tone_i),
        .audio_i (audio_i),
        .sel_i   (src_sel_i),
        .env_o   (env_new)
    );

    am_mod_mult #(.DW(DW)) u_mult (
        .carrier_i (pipe_q.carrier),
        .env_i     (pipe_q.env),
        .result_o  (mod_result)
    );

    am_mod_dac_fmt #(.DW(DW), .CW(CW)) u_fmt (
        .result_i (mod_result),
        .code_o   (code_new)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.carrier = carrier_i;
        pipe_d.env     = env_new;
        pipe_d.code    = code_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '{carrier: '0, env: '0, code: MID};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dac_code_o  = pipe_q.code;
    assign dac_blank_o = 1'b1;
    assign dac_sync_o  = 1'b1;
    assign dac_clk_o   = clk;

    assert_reset_midscale_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac_code_o == MID));

    assert_tone_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && ($signed(tone_i) <= SAT_KNEE))
        |=> ($signed(pipe_q.env) == $signed($past(tone_i)) + int'(OFFSET)));

    assert_sat_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!src_sel_i && ($signed(tone_i) > SAT_KNEE)) ||
         ( src_sel_i && ($signed(audio_i) > SAT_KNEE)))
        |=> (pipe_q.env == ENV_MAX));

    assert_env_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(pipe_q.env) >= ENV_FLOOR);

    assert_zero_carrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_q.carrier == '0) |=> (dac_code_o == MID));
endmodule

// File: tb/am_mod_dac_test.sv
module am_mod_dac_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] carrier = '0;
    logic [15:0] tone = '0;
    logic [15:0] audio = '0;
    logic        sel = 1'b0;
    logic [9:0]  code;
    logic        blank, sync, dclk;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    am_mod_dac uut (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .tone_i(tone),
        .audio_i(audio), .src_sel_i(sel), .dac_code_o(code),
        .dac_blank_o(blank), .dac_sync_o(sync), .dac_clk_o(dclk)
    );

    function automatic logic [9:0] ref_code(logic [15:0] car, logic [15:0] m);
        int          s;
        longint      p;
        logic [31:0] pb;
        logic [15:0] r;
        s = int'($signed(m)) + 16384;
        if (s > 32767) s = 32767;
        p  = longint'($signed(car)) * longint'(s);
        pb = p[31:0];
        r  = {pb[31], pb[29:15]};
        return r[15:6] + 10'd512;
    endfunction

    task automatic check(bit ok, string req, logic [9:0] act, logic [9:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] c, logic [15:0] t, logic [15:0] a, logic s);
        @(negedge clk);
        carrier = c; tone = t; audio = a; sel = s;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [9:0] exp_a;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(code == 10'd512, "R1 reset code", code, 10'd512);
        check(blank && sync, "R1 blank/sync in reset", {8'd0, blank, sync}, 10'd3);
        rst_n = 1'b1;
        @(negedge clk);
        check(code == 10'd512, "R1 first edge after reset", code, 10'd512);

        // R9: forwarded clock
        check(dclk == 1'b0, "R9 dac clock low", {9'd0, dclk}, 10'd0);
        @(posedge clk); #1;
        check(dclk == 1'b1, "R9 dac clock high", {9'd0, dclk}, 10'd1);

        // R5 corner products
        apply(16'h7FFF, 16'h3FFF, 16'h0000, 1'b0);
        check(code == 10'h3FF, "R5 max*max", code, 10'h3FF);
        apply(16'h8000, 16'h3FFF, 16'h0000, 1'b0);
        check(code == 10'h000, "R5 min*max", code, 10'h000);
        apply(16'h8000, 16'hC000, 16'h3FFF, 1'b0);
        check(code == 10'd512, "R5 zero envelope", code, 10'd512);

        // R4 saturation knee
        apply(16'h4000, 16'h3FFF, 16'h0000, 1'b0);
        check(code == 10'h2FF, "R4 knee exact", code, 10'h2FF);
        apply(16'h4000, 16'h4000, 16'h0000, 1'b0);
        check(code == 10'h2FF, "R4 just above knee", code, 10'h2FF);
        apply(16'h4000, 16'h0000, 16'h7FFF, 1'b1);
        check(code == 10'h2FF, "R4 audio full scale", code, 10'h2FF);
        apply(16'h4000, 16'h6000, 16'h0000, 1'b0);
        check(code == 10'h2FF, "R4 tone 0x6000", code, 10'h2FF);

        // R7 zero carrier
        for (int k = 0; k < 4; k++) begin
            logic [15:0] m;
            m = (k == 0) ? 16'h7FFF : (k == 1) ? 16'h8000 : (k == 2) ? 16'h3FFF : 16'h1234;
            apply(16'h0000, m, ~m, k[0]);
            check(code == 10'd512, "R7 zero carrier", code, 10'd512);
        end

        // R8 latency
        apply(16'h2000, 16'h1000, 16'h0000, 1'b0);
        exp_a = ref_code(16'h2000, 16'h1000);
        @(negedge clk);
        carrier = 16'hE000; tone = 16'h0000; audio = 16'h3000; sel = 1'b1;
        @(posedge clk); @(negedge clk);
        check(code == exp_a, "R8 old code held one cycle", code, exp_a);
        @(posedge clk); @(negedge clk);
        check(code == ref_code(16'hE000, 16'h3000), "R8 new code after two edges",
              code, ref_code(16'hE000, 16'h3000));

        // R2/R3/R6 grid sweep with the unselected source disturbed
        for (int ci = 0; ci < 64; ci++) begin
            for (int mi = 0; mi < 64; mi++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] c, m, other;
                    c     = 16'(ci * 1024 + ci * 7);
                    m     = 16'(mi * 1024 + mi * 13);
                    other = m ^ 16'hA5C3;
                    if (s == 0) begin
                        apply(c, m, other, 1'b0);
                        check(code == ref_code(c, m), "R2 tone selected, audio ignored (R6)",
                              code, ref_code(c, m));
                    end else begin
                        apply(c, other, m, 1'b1);
                        check(code == ref_code(c, m), "R3 audio selected, tone ignored (R6)",
                              code, ref_code(c, m));
                    end
                end
            end
        end
        check(blank && sync, "R1 blank/sync after run", {8'd0, blank, sync}, 10'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule